// File: doc/BRIEF.md
# Sleep-Period Reference Refresh Controller

While the chip sleeps, the regulator, the voltage reference and the low-voltage monitor are switched off to save power. This controller wakes them up at a fixed interval. It checks the supply and then switches them off again. A period counter advances on a one-cycle 32 kHz tick, delivered in the fast clock domain. A 2-bit select picks the interval. The interval table applies only while a 2-bit alternate-mode field is zero. For any other value of that field, no refresh is started.

When a refresh starts, five enables rise together: regulator, power switch, reference, reset monitor and oscillator. The sequence then passes through four timed phases, each lasting a fixed number of fast-clock cycles. The first phase is a start-up phase of two oscillator cycles by default. At the end of the start-up phase, the reference is sampled (a one-cycle strobe). After the next phase, the supply reference moves from the standby source to the main reference. After a settling phase, the reset monitor is sampled and every enable drops. A low-voltage result sets a sticky flag that the wakeup logic can read.

Top module: `slp_refresh_ctrl`

## Requirements
- R1: After reset, all five enables, `ref_sample`, `ref_main`, `mon_sample` and `low_volt` are 0.
- R2: While asleep with `alt_mode` = 00, a refresh starts on the tick that completes N counted ticks, with N = 256 for `duty_sel` 00, 1024 for 01, 64 for 10 and 16 for 11.
- R3: While `alt_mode` is not 00, no refresh starts and the tick count is held at zero. Once the field returns to 00, a full period is counted from zero.
- R4: A refresh holds all five enables high together for ENA_CYC+BG_CYC+SW_CYC+MON_CYC clock cycles. They rise on the clock edge that takes the starting tick.
- R5: `ref_sample` is high for exactly one cycle, the cycle that follows the first ENA_CYC enabled cycles.
- R6: `ref_main` is high from enabled cycle ENA_CYC+BG_CYC (counting from 0) until the enables drop, and it is low at all other times.
- R7: In the cycle after the enables drop, `mon_sample` is high for one cycle. The value of `lvd_in` (1 = low voltage) sampled at that edge is ORed into `low_volt`, which stays set while `sleep_active` remains 1.
- R8: The `duty_sel` value is captured when a period begins, either at sleep entry or at a refresh start. A change made during a period takes effect only for the period after it.
- R9: When `sleep_active` is 0, any refresh is abandoned with the enables low, the tick count is cleared, `low_volt` is cleared and no `mon_sample` is given.
- R10: Ticks that arrive during a refresh are not counted. The count restarts from zero after each refresh, so the next refresh comes a full period of ticks after the enables drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (oscillator domain) |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_active | input | 1 | 1 while the system is asleep |
| tick_32k | input | 1 | One-cycle pulse per 32 kHz period |
| duty_sel | input | 2 | Refresh interval select |
| alt_mode | input | 2 | Alternate-mode field; interval table used only at 00 |
| lvd_in | input | 1 | Reset-monitor comparator, 1 = low voltage |
| reg_en | output | 1 | Regulator enable |
| psw_en | output | 1 | Power switch enable |
| ref_en | output | 1 | Voltage reference enable |
| mon_en | output | 1 | Reset/low-voltage monitor enable |
| osc_en | output | 1 | Main oscillator enable |
| ref_sample | output | 1 | One-cycle strobe: sample the reference |
| ref_main | output | 1 | 1 = supply reference taken from the main reference |
| mon_sample | output | 1 | One-cycle strobe: reset monitor sampled |
| low_volt | output | 1 | Sticky low-voltage flag |

## Verification
The bench builds the controller with short phases: a 2-cycle start-up, then 3, 4 and 2 cycles, for 11 enabled cycles in all. It raises a tick every fourth clock. With these values the longest 1024-tick interval still fits in a few thousand cycles, and all four select codes can be measured end to end. Because the ticks keep arriving during every refresh, the rule that ticks are ignored mid-sequence is exercised each time. The short sequence also lets the bench place a sleep exit inside a running refresh and a low-voltage reading exactly on the monitor sample edge.

// File: rtl/slp_ref_pkg.sv
package slp_ref_pkg;

   localparam int PER_W = 11;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ENA,
      PH_BG,
      PH_SW,
      PH_MON
   } ph_e;

   function automatic logic [PER_W-1:0] period_of(input logic [1:0] sel);
      logic [PER_W-1:0] n;
      unique case (sel)
         2'b00:   n = PER_W'(256);
         2'b01:   n = PER_W'(1024);
         2'b10:   n = PER_W'(64);
         default: n = PER_W'(16);
      endcase
      return n;
   endfunction

endpackage

// File: rtl/slp_ref_period.sv
module slp_ref_period
   import slp_ref_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       arm,
   input  logic       tick,
   input  logic [1:0] sel,
   output logic       start
);

   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] cnt_q;

   assign start = run & arm & tick & (cnt_q == per_q - PER_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= period_of(2'b00);
         cnt_q <= '0;
      end else if (!run) begin
         per_q <= period_of(sel);
         cnt_q <= '0;
      end else if (start) begin
         per_q <= period_of(sel);
         cnt_q <= '0;
      end else if (!arm) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + PER_W'(1);
      end
   end

endmodule

// File: rtl/slp_ref_seq.sv
module slp_ref_seq
   import slp_ref_pkg::*;
#(
   parameter int ENA_CYC = 2,
   parameter int BG_CYC  = 20,
   parameter int SW_CYC  = 8,
   parameter int MON_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic start,
   input  logic lvd_in,
   output logic pwr_on,
   output logic ref_smp,
   output logic sel_main,
   output logic mon_smp,
   output logic lv_flag,
   output logic idle
);

   localparam int MAX_AB  = (ENA_CYC > BG_CYC) ? ENA_CYC : BG_CYC;
   localparam int MAX_CD  = (SW_CYC > MON_CYC) ? SW_CYC : MON_CYC;
   localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int TMR_W   = $clog2(MAX_CYC + 1);

   ph_e              ph_q, ph_nx;
   logic [TMR_W-1:0] tmr_q;
   logic [TMR_W-1:0] ph_len;
   logic             last;

   always_comb begin
      unique case (ph_q)
         PH_ENA:  begin ph_len = TMR_W'(ENA_CYC); ph_nx = PH_BG;   end
         PH_BG:   begin ph_len = TMR_W'(BG_CYC);  ph_nx = PH_SW;   end
         PH_SW:   begin ph_len = TMR_W'(SW_CYC);  ph_nx = PH_MON;  end
         PH_MON:  begin ph_len = TMR_W'(MON_CYC); ph_nx = PH_IDLE; end
         default: begin ph_len = TMR_W'(1);       ph_nx = PH_IDLE; end
      endcase
   end

   assign last = (tmr_q == ph_len - TMR_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         tmr_q   <= '0;
         ref_smp <= 1'b0;
         mon_smp <= 1'b0;
         lv_flag <= 1'b0;
      end else begin
         ref_smp <= 1'b0;
         mon_smp <= 1'b0;
         if (!run) begin
            ph_q    <= PH_IDLE;
            tmr_q   <= '0;
            lv_flag <= 1'b0;
         end else if (ph_q == PH_IDLE) begin
            tmr_q <= '0;
            if (start) ph_q <= PH_ENA;
         end else if (last) begin
            tmr_q <= '0;
            ph_q  <= ph_nx;
            if (ph_q == PH_ENA) ref_smp <= 1'b1;
            if (ph_q == PH_MON) begin
               mon_smp <= 1'b1;
               lv_flag <= lv_flag | lvd_in;
            end
         end else begin
            tmr_q <= tmr_q + TMR_W'(1);
         end
      end
   end

   assign pwr_on   = (ph_q != PH_IDLE);
   assign idle     = (ph_q == PH_IDLE);
   assign sel_main = (ph_q == PH_SW) || (ph_q == PH_MON);

endmodule

// File: rtl/slp_refresh_ctrl.sv
module slp_refresh_ctrl #(
   parameter int ENA_CYC = 2,
   parameter int BG_CYC  = 20,
   parameter int SW_CYC  = 8,
   parameter int MON_CYC = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_active,
   input  logic       tick_32k,
   input  logic [1:0] duty_sel,
   input  logic [1:0] alt_mode,
   input  logic       lvd_in,
   output logic       reg_en,
   output logic       psw_en,
   output logic       ref_en,
   output logic       mon_en,
   output logic       osc_en,
   output logic       ref_sample,
   output logic       ref_main,
   output logic       mon_sample,
   output logic       low_volt
);

   if (ENA_CYC < 1) begin : g_bad_ena
      $error("ENA_CYC must be at least 1");
   end
   if (BG_CYC < 1 || SW_CYC < 1 || MON_CYC < 1) begin : g_bad_phase
      $error("every phase needs at least one cycle");
   end

   logic start;
   logic idle;
   logic pwr_on;
   logic arm;

   assign arm = idle & (alt_mode == 2'b00);

   slp_ref_period u_period (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (sleep_active),
      .arm   (arm),
      .tick  (tick_32k),
      .sel   (duty_sel),
      .start (start)
   );

   slp_ref_seq #(
      .ENA_CYC (ENA_CYC),
      .BG_CYC  (BG_CYC),
      .SW_CYC  (SW_CYC),
      .MON_CYC (MON_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (sleep_active),
      .start    (start),
      .lvd_in   (lvd_in),
      .pwr_on   (pwr_on),
      .ref_smp  (ref_sample),
      .sel_main (ref_main),
      .mon_smp  (mon_sample),
      .lv_flag  (low_volt),
      .idle     (idle)
   );

   assign reg_en = pwr_on;
   assign psw_en = pwr_on;
   assign ref_en = pwr_on;
   assign mon_en = pwr_on;
   assign osc_en = pwr_on;

endmodule

// File: rtl/slp_refresh_chk.sv
module slp_refresh_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sleep_active,
   input logic [1:0] alt_mode,
   input logic       ref_en,
   input logic       ref_sample,
   input logic       ref_main,
   input logic       mon_sample,
   input logic       low_volt
);

   p_alt_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_mode != 2'b00 && !ref_en) |=> !ref_en);

   p_start_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_en) |-> (!ref_main && !ref_sample));

   p_smp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ref_sample |=> !ref_sample);

   p_smp_standby_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ref_sample |-> (ref_en && !ref_main));

   p_main_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ref_main |-> ref_en);

   p_mon_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mon_sample |-> (!ref_en && $past(ref_main)));

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(low_volt) && $past(sleep_active)) |-> low_volt);

   p_wake_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_active |=> (!ref_en && !low_volt && !mon_sample));

endmodule

bind slp_refresh_ctrl slp_refresh_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sleep_active (sleep_active),
   .alt_mode     (alt_mode),
   .ref_en       (ref_en),
   .ref_sample   (ref_sample),
   .ref_main     (ref_main),
   .mon_sample   (mon_sample),
   .low_volt     (low_volt)
);

// File: tb/slp_refresh_ctrl_tb_top.sv
module slp_refresh_ctrl_tb_top;

   localparam int ENA = 2;
   localparam int BG  = 3;
   localparam int SW  = 4;
   localparam int MON = 2;
   localparam int TOT = ENA + BG + SW + MON;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_active = 1'b0;
   logic       tick_32k = 1'b0;
   logic [1:0] duty_sel = 2'b00;
   logic [1:0] alt_mode = 2'b00;
   logic       lvd_in = 1'b0;
   logic       reg_en, psw_en, ref_en, mon_en, osc_en;
   logic       ref_sample, ref_main, mon_sample, low_volt;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   slp_refresh_ctrl #(
      .ENA_CYC (ENA),
      .BG_CYC  (BG),
      .SW_CYC  (SW),
      .MON_CYC (MON)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .sleep_active (sleep_active),
      .tick_32k     (tick_32k),
      .duty_sel     (duty_sel),
      .alt_mode     (alt_mode),
      .lvd_in       (lvd_in),
      .reg_en       (reg_en),
      .psw_en       (psw_en),
      .ref_en       (ref_en),
      .mon_en       (mon_en),
      .osc_en       (osc_en),
      .ref_sample   (ref_sample),
      .ref_main     (ref_main),
      .mon_sample   (mon_sample),
      .low_volt     (low_volt)
   );

   function automatic int ticks_for(input logic [1:0] s);
      case (s)
         2'b00:   return 256;
         2'b01:   return 1024;
         2'b10:   return 64;
         default: return 16;
      endcase
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, got, exp, $time);
      end
   endtask

   // tick generator: one-cycle pulse every fourth clock
   int div = 0;
   always @(negedge clk) begin
      div = (div + 1) % 4;
      tick_32k <= (div == 0);
   end

   // behavioural reference model
   int m_pos = -1;
   int m_cnt = 0;
   int m_per = 256;
   bit m_flag = 1'b0;
   bit m_mon = 1'b0;
   always @(posedge clk) begin
      m_mon = 1'b0;
      if (!rst_n) begin
         m_pos = -1; m_cnt = 0; m_per = 256; m_flag = 1'b0;
      end else if (!sleep_active) begin
         m_pos = -1; m_cnt = 0; m_per = ticks_for(duty_sel); m_flag = 1'b0;
      end else if (m_pos >= 0) begin
         m_pos++;
         if (m_pos == TOT) begin
            m_pos = -1; m_mon = 1'b1; m_flag = m_flag | lvd_in;
         end
      end else if (alt_mode != 2'b00) begin
         m_cnt = 0;
      end else if (tick_32k) begin
         if (m_cnt == m_per - 1) begin
            m_pos = 0; m_cnt = 0; m_per = ticks_for(duty_sel);
         end else begin
            m_cnt++;
         end
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         int en_exp;
         en_exp = (m_pos >= 0) ? 1 : 0;
         chk("R4 enables", int'({reg_en, psw_en, ref_en, mon_en, osc_en}),
             en_exp ? 31 : 0);
         chk("R5 ref_sample", int'(ref_sample), (m_pos == ENA) ? 1 : 0);
         chk("R6 ref_main", int'(ref_main), (m_pos >= ENA + BG) ? 1 : 0);
         chk("R7 mon_sample", int'(mon_sample), int'(m_mon));
         chk("R7 low_volt", int'(low_volt), int'(m_flag));
      end
   end

   // counted ticks since the last refresh (bench view of R2/R10)
   int tcnt = 0;
   always @(posedge clk) begin
      if (!sleep_active || ref_en || alt_mode != 2'b00) tcnt <= 0;
      else if (tick_32k) tcnt <= tcnt + 1;
   end

   task automatic wait_start(input string tag, input int exp);
      bit prev;
      bit seen;
      prev = ref_en;
      seen = 1'b0;
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         if (ref_en && !prev) begin
            seen = 1'b1;
            break;
         end
         prev = ref_en;
      end
      if (!seen) chk({tag, " no refresh"}, 0, 1);
      else chk(tag, tcnt, exp);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int starts;
      repeat (5) @(negedge clk);
      chk("R1 enables", int'({reg_en, psw_en, ref_en, mon_en, osc_en}), 0);
      chk("R1 strobes", int'({ref_sample, ref_main, mon_sample, low_volt}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      sleep_active = 1'b1;

      wait_start("R2 code 00", 256);
      wait_start("R10 restart after refresh", 256);
      duty_sel = 2'b01;
      wait_start("R8 old period kept", 256);
      wait_start("R2 code 01", 1024);
      duty_sel = 2'b10;
      wait_start("R8 old period kept", 1024);
      wait_start("R2 code 10", 64);
      duty_sel = 2'b11;
      wait_start("R8 old period kept", 64);
      wait_start("R2 code 11", 16);

      // R7: low voltage seen at the monitor sample edge
      lvd_in = 1'b1;
      while (!mon_sample) @(negedge clk);
      lvd_in = 1'b0;
      @(negedge clk);
      chk("R7 flag set", int'(low_volt), 1);
      wait_start("R7 period", 16);
      while (!mon_sample) @(negedge clk);
      @(negedge clk);
      chk("R7 flag sticky", int'(low_volt), 1);

      // R3: alternate mode blocks refreshes
      while (ref_en) @(negedge clk);
      alt_mode = 2'b01;
      starts = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (ref_en) starts++;
      end
      alt_mode = 2'b11;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (ref_en) starts++;
      end
      chk("R3 no refresh in alt mode", starts, 0);
      alt_mode = 2'b00;
      wait_start("R3 full period after alt", 16);

      // R9: leave sleep inside a refresh
      repeat (3) @(negedge clk);
      sleep_active = 1'b0;
      @(negedge clk);
      chk("R9 enables off", int'(ref_en), 0);
      chk("R9 flag cleared", int'(low_volt), 0);
      repeat (5) @(negedge clk);
      sleep_active = 1'b1;
      wait_start("R9 count restarted", 16);
      repeat (TOT + 3) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule